// File: doc/BRIEF.md
# Age-on-Bypass Install/Bypass Controller for a Direct-Mapped Cache

This block makes the fill decision for a direct-mapped cache whose tags and per-line metadata live off-chip. Each set holds one resident line and a small reuse-prediction score. A low score means the line is expected to be touched again soon, and the highest score means it is not. Tag comparison happens elsewhere. The controller receives a set index together with a hit flag for each access. On a miss it chooses one of two outcomes: replace the resident line with the incoming one, or leave the resident line in place and bypass the incoming one.

A direct-mapped set offers no choice of victim. To protect a line that is still predicted useful, the controller bypasses the incoming line instead. Each bypass raises the resident line's score by one step. A line that is no longer used therefore ages out after a bounded number of conflicting misses. Any change to a line's score is sent out as a state-write request, so the memory side can charge that write against its bandwidth. Hits reset the score to zero. Newly installed lines start one step below the distant level.

Top module: `aob_repl_ctrl`

## Requirements
- R1: After reset every set is empty, and the first miss to a set is an install (`dec_install`=1) that writes score 2 for that set.
- R2: A miss to a valid line with score 0, 1 or 2 is a bypass (`dec_install`=0), and its state write carries the old score plus one.
- R3: A miss to a valid line with score 3 (distant) is an install, and its state write carries score 2.
- R4: A hit gives no decision. It writes score 0 when the old score was non-zero and writes nothing when the score was already 0.
- R5: While a decision is offered and `dec_ready` is low, `dec_valid`, `dec_install` and `dec_set` hold steady and no state write is issued.
- R6: Each miss gives exactly one decision. Its state write appears in the cycle the decision is accepted and names the same set.
- R7: A request is taken on the clock edge after it is offered with `req_ready` high, and its result is visible in the following cycle. `req_ready` is low only while a decision waits for `dec_ready`.
- R8: Aging saturates and never wraps. After a hit, a line survives exactly three conflicting misses and the fourth installs. A freshly installed line survives exactly one.
- R9: Sets are independent. Activity on one set never changes the decisions or writes seen for another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Controller can take a request |
| req_set | input | IDX_W | Set index of the access |
| req_hit | input | 1 | 1 = tag matched (hit), 0 = miss |
| dec_valid | output | 1 | Miss decision offered |
| dec_ready | input | 1 | Consumer accepts the decision |
| dec_install | output | 1 | 1 = install incoming line, 0 = bypass |
| dec_set | output | IDX_W | Set the decision applies to |
| upd_valid | output | 1 | State-write request this cycle |
| upd_set | output | IDX_W | Set whose score is written |
| upd_rrpv | output | 2 | New score (0 near reuse .. 3 distant) |

## Verification
If a set's stored score is wrong, the error shows at the ports no later than the next access to that set. It appears as the wrong install or bypass choice, as a state write carrying the wrong value, or as a hit write that is missing or should not be there. An aging step lost through wrap-around or a failed write changes how many bypasses come before the next install. The bench therefore counts those bypass runs for every set. Corrupted valid bits show on the first miss after reset.

// File: rtl/aob_pkg.sv
package aob_pkg;
    localparam int RRPV_W = 2;
    typedef logic [RRPV_W-1:0] rrpv_t;

    localparam rrpv_t RRPV_NEAR    = '0;
    localparam rrpv_t RRPV_DISTANT = '1;
    localparam rrpv_t RRPV_INSERT  = RRPV_DISTANT - rrpv_t'(1);

    typedef enum logic {
        DEC_BYPASS  = 1'b0,
        DEC_INSTALL = 1'b1
    } dec_e;

    typedef struct packed {
        logic  vld;
        rrpv_t rrpv;
    } line_st_t;

    typedef struct packed {
        dec_e     dec;
        line_st_t nxt;
        logic     changed;
    } verdict_t;

    function automatic rrpv_t age_sat(input rrpv_t v);
        return (v == RRPV_DISTANT) ? v : v + rrpv_t'(1);
    endfunction
endpackage

// File: rtl/aob_state_array.sv
module aob_state_array
    import aob_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output line_st_t         rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_st_t         wr_data
);
    localparam int SETS = 1 << IDX_W;

    line_st_t lines [SETS];

    for (genvar g = 0; g < SETS; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                lines[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                lines[g] <= wr_data;
            end
        end
    end

    assign rd_data = lines[rd_idx];
endmodule

// File: rtl/aob_decide.sv
module aob_decide
    import aob_pkg::*;
(
    input  logic     hit,
    input  line_st_t cur,
    output verdict_t verdict
);
    always_comb begin
        verdict = '0;
        if (hit) begin
            verdict.dec      = DEC_BYPASS;
            verdict.nxt.vld  = 1'b1;
            verdict.nxt.rrpv = RRPV_NEAR;
            verdict.changed  = !cur.vld || (cur.rrpv != RRPV_NEAR);
        end else if (!cur.vld || (cur.rrpv == RRPV_DISTANT)) begin
            verdict.dec      = DEC_INSTALL;
            verdict.nxt.vld  = 1'b1;
            verdict.nxt.rrpv = RRPV_INSERT;
            verdict.changed  = 1'b1;
        end else begin
            verdict.dec      = DEC_BYPASS;
            verdict.nxt.vld  = 1'b1;
            verdict.nxt.rrpv = age_sat(cur.rrpv);
            verdict.changed  = 1'b1;
        end
    end
endmodule

// File: rtl/aob_req_stage.sv
module aob_req_stage #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_set,
    input  logic             req_hit,
    output logic             req_ready,
    input  logic             retire,
    output logic             pend_valid,
    output logic [IDX_W-1:0] pend_set,
    output logic             pend_hit
);
    assign req_ready = !pend_valid || retire;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_set   <= '0;
            pend_hit   <= 1'b0;
        end else if (req_ready) begin
            pend_valid <= req_valid;
            if (req_valid) begin
                pend_set <= req_set;
                pend_hit <= req_hit;
            end
        end
    end
endmodule

// File: rtl/aob_repl_ctrl.sv
module aob_repl_ctrl
    import aob_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [IDX_W-1:0] req_set,
    input  logic             req_hit,
    output logic             dec_valid,
    input  logic             dec_ready,
    output logic             dec_install,
    output logic [IDX_W-1:0] dec_set,
    output logic             upd_valid,
    output logic [IDX_W-1:0] upd_set,
    output logic [RRPV_W-1:0] upd_rrpv
);
    logic             pend_valid;
    logic [IDX_W-1:0] pend_set;
    logic             pend_hit;
    logic             retire;
    line_st_t         cur_line;
    verdict_t         verdict;

    assign retire = pend_valid && (pend_hit || dec_ready);

    aob_req_stage #(.IDX_W(IDX_W)) u_stage (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_set    (req_set),
        .req_hit    (req_hit),
        .req_ready  (req_ready),
        .retire     (retire),
        .pend_valid (pend_valid),
        .pend_set   (pend_set),
        .pend_hit   (pend_hit)
    );

    aob_state_array #(.IDX_W(IDX_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (pend_set),
        .rd_data (cur_line),
        .wr_en   (retire && verdict.changed),
        .wr_idx  (pend_set),
        .wr_data (verdict.nxt)
    );

    aob_decide u_decide (
        .hit     (pend_hit),
        .cur     (cur_line),
        .verdict (verdict)
    );

    assign dec_valid   = pend_valid && !pend_hit;
    assign dec_install = (verdict.dec == DEC_INSTALL);
    assign dec_set     = pend_set;
    assign upd_valid   = retire && verdict.changed;
    assign upd_set     = pend_set;
    assign upd_rrpv    = verdict.nxt.rrpv;
endmodule

// File: rtl/aob_repl_ctrl_chk.sv
module aob_repl_ctrl_chk
    import aob_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_hit,
    input logic             dec_valid,
    input logic             dec_ready,
    input logic             dec_install,
    input logic [IDX_W-1:0] dec_set,
    input logic             upd_valid,
    input logic [IDX_W-1:0] upd_set,
    input rrpv_t            upd_rrpv
);
    AST_INSTALL_SCORE: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_ready && dec_install) |-> (upd_valid && upd_rrpv == RRPV_INSERT)); // R3

    AST_BYPASS_AGES: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_ready && !dec_install) |-> (upd_valid && upd_rrpv != RRPV_NEAR)); // R2

    AST_HIT_NO_DECISION: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_hit) |=> !dec_valid); // R4

    AST_HIT_WRITE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !dec_valid) |-> (upd_rrpv == RRPV_NEAR)); // R4

    AST_DEC_HELD: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_install) && $stable(dec_set))); // R5

    AST_NO_EARLY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_ready) |-> !upd_valid); // R5

    AST_WRITE_SAME_SET: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && dec_valid) |-> (upd_set == dec_set && dec_ready)); // R6

    AST_READY_ONLY_STALL: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> (dec_valid && !dec_ready)); // R7
endmodule

bind aob_repl_ctrl aob_repl_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_hit     (req_hit),
    .dec_valid   (dec_valid),
    .dec_ready   (dec_ready),
    .dec_install (dec_install),
    .dec_set     (dec_set),
    .upd_valid   (upd_valid),
    .upd_set     (upd_set),
    .upd_rrpv    (upd_rrpv)
);

// File: tb/aob_repl_ctrl_test.sv
module aob_repl_ctrl_test;
    localparam int IDX_W = 3;
    localparam int SETS  = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [IDX_W-1:0] req_set = '0;
    logic             req_hit = 1'b0;
    logic             dec_valid;
    logic             dec_ready = 1'b0;
    logic             dec_install;
    logic [IDX_W-1:0] dec_set;
    logic             upd_valid;
    logic [IDX_W-1:0] upd_set;
    logic [1:0]       upd_rrpv;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    bit       exp_vld [SETS];
    int       exp_score [SETS];

    always #2 clk = ~clk;

    aob_repl_ctrl #(.IDX_W(IDX_W)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_set(req_set), .req_hit(req_hit),
        .dec_valid(dec_valid), .dec_ready(dec_ready),
        .dec_install(dec_install), .dec_set(dec_set),
        .upd_valid(upd_valid), .upd_set(upd_set), .upd_rrpv(upd_rrpv)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One access, fully completed; reports whether the miss installed.
    task automatic op(input int s, input bit hit, input int stall, output bit installed);
        bit ins;
        int nv;
        bit ch;
        string tag;
        ins = 1'b0;
        if (hit) begin
            nv = 0;
            ch = !exp_vld[s] || exp_score[s] != 0;
        end else if (!exp_vld[s] || exp_score[s] == 3) begin
            ins = 1'b1;
            nv  = 2;
            ch  = 1'b1;
        end else begin
            nv = exp_score[s] + 1;
            ch = 1'b1;
        end
        tag = hit ? "R4" : (ins ? (exp_vld[s] ? "R3" : "R1") : "R2");

        @(negedge clk);
        req_valid = 1'b1;
        req_set   = IDX_W'(s);
        req_hit   = hit;
        chk(req_ready == 1'b1, "R7", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (hit) begin
            chk(dec_valid == 1'b0, "R4", int'(dec_valid), 0);
            chk(upd_valid == ch, "R4", int'(upd_valid), int'(ch));
            if (ch) begin
                chk(upd_set == IDX_W'(s), "R9", int'(upd_set), s);
                chk(upd_rrpv == 2'(nv), "R4", int'(upd_rrpv), nv);
            end
            chk(req_ready == 1'b1, "R7", int'(req_ready), 1);
        end else begin
            chk(dec_valid == 1'b1, "R6", int'(dec_valid), 1);
            chk(dec_install == ins, tag, int'(dec_install), int'(ins));
            chk(dec_set == IDX_W'(s), "R9", int'(dec_set), s);
            for (int k = 0; k < stall; k++) begin
                chk(upd_valid == 1'b0, "R5", int'(upd_valid), 0);
                chk(req_ready == 1'b0, "R7", int'(req_ready), 0);
                @(negedge clk);
                chk(dec_valid == 1'b1 && dec_install == ins, "R5", int'(dec_install), int'(ins));
            end
            dec_ready = 1'b1;
            #1;
            chk(upd_valid == 1'b1, "R6", int'(upd_valid), 1);
            chk(upd_set == IDX_W'(s), "R6", int'(upd_set), s);
            chk(upd_rrpv == 2'(nv), tag, int'(upd_rrpv), nv);
            @(negedge clk);
            dec_ready = 1'b0;
            chk(dec_valid == 1'b0, "R6", int'(dec_valid), 0);
        end
        exp_vld[s]   = 1'b1;
        exp_score[s] = nv;
        installed    = ins;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        bit inst;
        int nbyp;
        for (int s = 0; s < SETS; s++) begin
            exp_vld[s]   = 1'b0;
            exp_score[s] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(dec_valid == 1'b0, "R1", int'(dec_valid), 0);
        chk(upd_valid == 1'b0, "R1", int'(upd_valid), 0);
        chk(req_ready == 1'b1, "R7", int'(req_ready), 1);

        // R1: first miss to each empty set installs
        for (int s = 0; s < SETS; s++) op(s, 1'b0, s % 3, inst);

        // R4: hit from score 2 writes 0, repeated hit writes nothing
        for (int s = 0; s < SETS; s++) begin
            op(s, 1'b1, 0, inst);
            op(s, 1'b1, 0, inst);
        end

        // R8: protected run lengths, counted per set
        for (int s = 0; s < SETS; s++) begin
            nbyp = 0;
            inst = 1'b0;
            for (int k = 0; k < 8 && !inst; k++) begin
                op(s, 1'b0, s % 2, inst);
                if (!inst) nbyp++;
            end
            chk(nbyp == 3, "R8", nbyp, 3);
            nbyp = 0;
            inst = 1'b0;
            for (int k = 0; k < 8 && !inst; k++) begin
                op(s, 1'b0, 0, inst);
                if (!inst) nbyp++;
            end
            chk(nbyp == 1, "R8", nbyp, 1);
        end

        // R9: interleaved mixes across sets
        for (int r = 0; r < 12; r++) begin
            for (int s = 0; s < SETS; s++) begin
                op((s * 3 + r) % SETS, ((r + s) % 3) == 0, (r * s) % 3, inst);
            end
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule